// File: doc/BRIEF.md
# Computer-Operating-Properly Watchdog with Pad-Qualified Reset

This block watches a small microcontroller for loss of control. A short counter advances on single-cycle ticks from an external prescaler. Software must service it by writing a one to a control bit before the counter reaches its last state. When the counter expires, the block pulls the chip reset line low. The reset pad is open-drain in style. The block reads the pad back and lets go of the line only after the pad has read low for a minimum number of clocks.

Two static straps configure the block. The first sets whether the watchdog is armed after every reset, including the resets it raises itself. The second sets what happens during WAIT: either the counter keeps running, or it is cleared and frozen until WAIT ends. Software can arm the watchdog but can never disarm it. While the watchdog is armed, a STOP request is turned into a watchdog reset. That reset carries a flag telling the clock logic to skip the oscillator start-up delay. A cause code records which event produced the last watchdog reset and holds it until power-on reset.

Top module: `cop_watchdog`

## Requirements
- R1: After power-on reset `rst`, `reset_n_drive` is 1, `rst_request` is 0, `reset_cause` is 2'b00 and `skip_osc_delay` is 0. The armed state equals `cfg_en_strap`, and the counter is cleared.
- R2: A write (`ctl_wr`=1) with `ctl_wdata`=1 arms the watchdog and clears the counter. A write with `ctl_wdata`=0 neither disarms the watchdog nor changes the counter.
- R3: While armed, the counter needs 7 ticks (`tick_en` pulses) from the cleared state to expire. `reset_n_drive` falls and `rst_request` rises in the clock after the 7th tick, and 6 ticks raise no reset.
- R4: A service write in the same cycle as a tick takes priority. The counter is cleared and no reset is raised.
- R5: While the watchdog is disarmed, ticks never raise a reset.
- R6: A `stop_req` while armed raises a reset in the next clock, with `reset_cause`=2'b10 and `skip_osc_delay`=1. A `stop_req` while disarmed has no effect.
- R7: With `cfg_wait_run`=0, an active `wait_active` clears and freezes the counter. After WAIT ends, 7 fresh ticks are needed to expire.
- R8: With `cfg_wait_run`=1, the counter keeps counting during WAIT and expires after 7 ticks in total.
- R9: The reset drive is held while the sampled pad reads high. It is released LOW_MIN+1 clocks after the pad starts reading low; with the pad looped back, that is LOW_MIN+1 clocks after the drive falls.
- R10: After a watchdog reset, the armed state is reloaded from `cfg_en_strap`, and control writes made while the reset is held are ignored.
- R11: A timeout reset sets `reset_cause`=2'b01 and clears `skip_osc_delay`. The cause and flag stay unchanged until the next watchdog reset or power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_en_strap | input | 1 | Static strap: armed state after any reset |
| cfg_wait_run | input | 1 | Static strap: 1 keeps counting in WAIT, 0 clears and freezes |
| tick_en | input | 1 | Single-cycle prescaler tick |
| ctl_wr | input | 1 | Control bit write strobe |
| ctl_wdata | input | 1 | Control bit write data (1 arms and services) |
| stop_req | input | 1 | CPU request to enter STOP |
| wait_active | input | 1 | CPU is in WAIT |
| pin_level | input | 1 | Sampled level of the external reset pad |
| reset_n_drive | output | 1 | 0 pulls the reset pad low |
| rst_request | output | 1 | Internal chip reset request, high while the pad is driven |
| skip_osc_delay | output | 1 | Last watchdog reset came from STOP; skip start-up delay |
| reset_cause | output | 2 | 00 none, 01 timeout, 10 STOP |

## Verification
A corrupted counter value shows up within a single tick sequence as a reset that arrives one or more ticks early or late. That is why each scenario counts the ticks exactly and checks both the 6-tick and the 7-tick boundary. A wrong armed state only appears at the next expiry window: a watchdog that never fires, or one that fires after being disarmed. A fault in the release logic shows up in the number of clocks the drive stays low, which is compared exactly, both with the pad looped back and with the pad held high from outside.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_TIMEOUT = 2'b01,
    CAUSE_STOP    = 2'b10
  } cop_cause_e;
endpackage

// File: rtl/cop_tick_counter.sv
// Armed flag and tick counter. Expires on the tick that would reach the final state.
module cop_tick_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_en,
  input  logic             wd_clear,
  input  logic             svc,
  input  logic             tick,
  input  logic             run_ok,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  localparam int unsigned      FINAL_VAL = (1 << CNT_W) - 1;
  localparam logic [CNT_W-1:0] PRE_FINAL = CNT_W'(FINAL_VAL - 1);

  always_ff @(posedge clk) begin
    if (rst || wd_clear) begin
      en_q  <= strap_en;
      cnt_q <= '0;
    end else begin
      if (svc) en_q <= 1'b1;
      if (svc || !en_q || !run_ok) cnt_q <= '0;
      else if (tick)               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = en_q && tick && !svc && run_ok && (cnt_q == PRE_FINAL);
endmodule

// File: rtl/cop_reset_stretch.sv
// Holds the reset drive until the read-back pad has been low long enough.
module cop_reset_stretch #(
  parameter int unsigned LOW_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic pin_level,
  output logic hold_q
);
  localparam int unsigned LOW_W = $clog2(LOW_MIN + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(LOW_MIN - 1);

  logic             pin_q;
  logic [LOW_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b1;
      hold_q  <= 1'b0;
      low_cnt <= '0;
    end else begin
      pin_q <= pin_level;
      if (!hold_q) begin
        low_cnt <= '0;
        if (fire) hold_q <= 1'b1;
      end else if (pin_q) begin
        low_cnt <= '0;
      end else if (low_cnt == LOW_LAST) begin
        hold_q  <= 1'b0;
        low_cnt <= '0;
      end else begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog
  import cop_pkg::*;
#(
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned LOW_MIN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_en_strap,
  input  logic       cfg_wait_run,
  input  logic       tick_en,
  input  logic       ctl_wr,
  input  logic       ctl_wdata,
  input  logic       stop_req,
  input  logic       wait_active,
  input  logic       pin_level,
  output logic       reset_n_drive,
  output logic       rst_request,
  output logic       skip_osc_delay,
  output logic [1:0] reset_cause
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             expire;
  logic             hold_q;
  logic             svc;
  logic             run_ok;
  logic             stop_hit;
  logic             fire;
  cop_cause_e       cause_q;
  logic             skip_q;

  assign svc      = ctl_wr && ctl_wdata && !hold_q;
  assign run_ok   = cfg_wait_run || !wait_active;
  assign stop_hit = en_q && stop_req;
  assign fire     = !hold_q && (expire || stop_hit);

  cop_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .strap_en (cfg_en_strap),
    .wd_clear (fire || hold_q),
    .svc      (svc),
    .tick     (tick_en),
    .run_ok   (run_ok),
    .en_q     (en_q),
    .cnt_q    (cnt_q),
    .expire   (expire)
  );

  cop_reset_stretch #(.LOW_MIN(LOW_MIN)) u_rst (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .pin_level (pin_level),
    .hold_q    (hold_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= CAUSE_NONE;
      skip_q  <= 1'b0;
    end else if (fire) begin
      cause_q <= stop_hit ? CAUSE_STOP : CAUSE_TIMEOUT;
      skip_q  <= stop_hit;
    end
  end

  assign reset_n_drive  = !hold_q;
  assign rst_request    = hold_q;
  assign skip_osc_delay = skip_q;
  assign reset_cause    = cause_q;
endmodule

// File: rtl/cop_watchdog_chk.sv
module cop_watchdog_chk
  import cop_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ctl_wr,
  input logic             ctl_wdata,
  input logic             stop_req,
  input logic             wait_active,
  input logic             cfg_wait_run,
  input logic             pin_level,
  input logic             reset_n_drive,
  input logic             rst_request,
  input logic             skip_osc_delay,
  input logic [1:0]       reset_cause,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !rst_request) |=> (en_q || !reset_n_drive));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q != {CNT_W{1'b1}});

  // R4
  svc_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ctl_wdata && !rst_request && !stop_req) |=> (reset_n_drive && cnt_q == '0));

  // R5
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_n_drive) |-> $past(en_q));

  // R6
  stop_fire_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && stop_req && !rst_request) |=>
      (!reset_n_drive && reset_cause == CAUSE_STOP && skip_osc_delay));

  // R7
  wait_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wait_run && wait_active && !stop_req && !rst_request) |=>
      (cnt_q == '0 && reset_n_drive));

  // R9
  release_pin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_n_drive) |-> ($past(pin_level, 2) == 1'b0));

  // R11
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_n_drive && reset_cause != CAUSE_NONE) |=>
      ($stable(reset_cause) || $fell(reset_n_drive)));

  // R11
  skip_match_chk: assert property (@(posedge clk) disable iff (rst)
    skip_osc_delay == (reset_cause == CAUSE_STOP));
endmodule

bind cop_watchdog cop_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .ctl_wr         (ctl_wr),
  .ctl_wdata      (ctl_wdata),
  .stop_req       (stop_req),
  .wait_active    (wait_active),
  .cfg_wait_run   (cfg_wait_run),
  .pin_level      (pin_level),
  .reset_n_drive  (reset_n_drive),
  .rst_request    (rst_request),
  .skip_osc_delay (skip_osc_delay),
  .reset_cause    (reset_cause),
  .en_q           (en_q),
  .cnt_q          (cnt_q)
);

// File: tb/tb_cop_watchdog.sv
`timescale 1ns/1ps
module tb_cop_watchdog;
  localparam int LOW_MIN = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_en_strap = 1'b1;
  logic cfg_wait_run = 1'b0;
  logic tick_en = 1'b0;
  logic ctl_wr = 1'b0;
  logic ctl_wdata = 1'b0;
  logic stop_req = 1'b0;
  logic wait_active = 1'b0;
  logic force_hi = 1'b0;
  logic pin_level;
  logic reset_n_drive;
  logic rst_request;
  logic skip_osc_delay;
  logic [1:0] reset_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign pin_level = force_hi | reset_n_drive;

  cop_watchdog #(.CNT_W(3), .LOW_MIN(LOW_MIN)) dut (
    .clk(clk), .rst(rst), .cfg_en_strap(cfg_en_strap), .cfg_wait_run(cfg_wait_run),
    .tick_en(tick_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stop_req(stop_req),
    .wait_active(wait_active), .pin_level(pin_level), .reset_n_drive(reset_n_drive),
    .rst_request(rst_request), .skip_osc_delay(skip_osc_delay), .reset_cause(reset_cause)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic por(input logic en, input logic wrun);
    cfg_en_strap = en; cfg_wait_run = wrun;
    tick_en = 0; ctl_wr = 0; ctl_wdata = 0; stop_req = 0; wait_active = 0; force_hi = 0;
    rst = 1; step(); step(); rst = 0;
    chk("R1", "drive after por", reset_n_drive, 1);
    chk("R1", "request after por", rst_request, 0);
    chk("R1", "cause after por", reset_cause, 0);
    chk("R1", "skip after por", skip_osc_delay, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1; step(); tick_en = 0; step();
    end
  endtask

  task automatic last_tick();
    tick_en = 1; step(); tick_en = 0;
  endtask

  task automatic write_bit(input logic v);
    ctl_wr = 1; ctl_wdata = v; step(); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic wait_release(input string req, input int exp);
    int n = 0;
    while (reset_n_drive == 1'b0 && n < 200) begin step(); n++; end
    chk(req, "clocks until release", n, exp);
    chk(req, "request cleared on release", rst_request, 0);
  endtask

  task automatic t_timeout();
    por(1, 0);
    ticks(6);
    chk("R3", "no reset after 6 ticks", reset_n_drive, 1);
    last_tick();
    chk("R3", "drive low after 7th tick", reset_n_drive, 0);
    chk("R3", "request after 7th tick", rst_request, 1);
    chk("R11", "timeout cause", reset_cause, 1);
    chk("R11", "timeout skip flag", skip_osc_delay, 0);
    wait_release("R9", LOW_MIN + 1);
  endtask

  task automatic t_write0();
    por(1, 0);
    ticks(3);
    write_bit(0);
    ticks(3);
    chk("R2", "write 0 keeps count", reset_n_drive, 1);
    last_tick();
    chk("R2", "write 0 does not disarm", reset_n_drive, 0);
    wait_release("R9", LOW_MIN + 1);
  endtask

  task automatic t_service();
    por(1, 0);
    ticks(5);
    write_bit(1);
    ticks(6);
    chk("R2", "service clears count", reset_n_drive, 1);
    last_tick();
    chk("R2", "expiry 7 ticks after service", reset_n_drive, 0);
    wait_release("R9", LOW_MIN + 1);
  endtask

  task automatic t_svc_prio();
    por(1, 0);
    ticks(6);
    tick_en = 1; ctl_wr = 1; ctl_wdata = 1; step();
    tick_en = 0; ctl_wr = 0; ctl_wdata = 0;
    chk("R4", "service beats tick", reset_n_drive, 1);
    ticks(6);
    chk("R4", "count reloaded", reset_n_drive, 1);
    last_tick();
    chk("R4", "expiry after reload", reset_n_drive, 0);
    wait_release("R9", LOW_MIN + 1);
  endtask

  task automatic t_disarmed();
    por(0, 0);
    ticks(12);
    chk("R5", "disarmed no reset", reset_n_drive, 1);
    chk("R1", "strap 0 leaves disarmed", rst_request, 0);
    write_bit(1);
    ticks(6);
    chk("R2", "armed by write, 6 ticks", reset_n_drive, 1);
    last_tick();
    chk("R2", "armed by write expires", reset_n_drive, 0);
    wait_release("R9", LOW_MIN + 1);
    ticks(12);
    chk("R10", "rearm from strap 0 after reset", reset_n_drive, 1);
  endtask

  task automatic t_stop();
    por(0, 0);
    stop_req = 1; step(); stop_req = 0;
    chk("R6", "stop ignored when disarmed", reset_n_drive, 1);
    chk("R6", "cause untouched when disarmed", reset_cause, 0);
    write_bit(1);
    stop_req = 1; step(); stop_req = 0;
    chk("R6", "stop raises reset", reset_n_drive, 0);
    chk("R6", "stop cause", reset_cause, 2);
    chk("R6", "skip flag set", skip_osc_delay, 1);
    write_bit(1);
    wait_release("R9", LOW_MIN);
    ticks(12);
    chk("R10", "write during hold ignored", reset_n_drive, 1);
    chk("R11", "stop cause held", reset_cause, 2);
    chk("R11", "skip flag held", skip_osc_delay, 1);
    write_bit(1);
    ticks(6);
    last_tick();
    chk("R11", "later timeout cause", reset_cause, 1);
    chk("R11", "later timeout clears skip", skip_osc_delay, 0);
    wait_release("R9", LOW_MIN + 1);
    por(1, 0);
  endtask

  task automatic t_wait_freeze();
    por(1, 0);
    ticks(5);
    wait_active = 1;
    ticks(10);
    chk("R7", "frozen in wait", reset_n_drive, 1);
    wait_active = 0; step();
    ticks(6);
    chk("R7", "cleared on wait entry", reset_n_drive, 1);
    last_tick();
    chk("R7", "resumes after wait", reset_n_drive, 0);
    wait_release("R9", LOW_MIN + 1);
  endtask

  task automatic t_wait_run();
    por(1, 1);
    ticks(3);
    wait_active = 1;
    ticks(3);
    chk("R8", "counting in wait, 6 ticks", reset_n_drive, 1);
    last_tick();
    chk("R8", "expires in wait", reset_n_drive, 0);
    wait_active = 0;
    wait_release("R9", LOW_MIN + 1);
  endtask

  task automatic t_pin_held();
    por(1, 0);
    force_hi = 1;
    ticks(6);
    last_tick();
    chk("R9", "drive low with pad high", reset_n_drive, 0);
    repeat (30) step();
    chk("R9", "held while pad high", reset_n_drive, 0);
    force_hi = 0;
    wait_release("R9", LOW_MIN + 1);
  endtask

  initial begin
    t_timeout();
    t_write0();
    t_service();
    t_svc_prio();
    t_disarmed();
    t_stop();
    t_wait_freeze();
    t_wait_run();
    t_pin_held();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule